// File: doc/BRIEF.md
# Sector Buffer Transfer Engine

This block drains data from a 16 KiB byte-addressed sector buffer. Software loads a byte count, a buffer start address and a DMA base address, then issues a start pulse with a 3-bit destination code. The data is then pulled out in one of two ways. In host mode, a CPU reads one 16-bit word per strobe. In DMA mode, the block pushes words onto a write port aimed at one of three destination memories: a 4 KiB PCM memory, a 512 KiB program memory or a 256 KiB word memory.

The buffer port is word-wide with an asynchronous read. The word at index `buf_rd_addr` comes back on `buf_rd_data` in the same cycle, with the byte at the even address in bits 15:8 (big-endian). The DMA write port is a valid/ready stream. `dma_valid` may rise without waiting for `dma_ready`. Once `dma_valid` is high, it stays high with `dma_waddr` and `dma_wdata` unchanged until the cycle `dma_ready` is sampled high; the only exception is a withdrawal of `out_en`. A word moves on each rising edge where both are high, so at most one word moves per clock. All control and status pins are plain levels or single-cycle pulses. Status flags named `_n` are active-low.

Top module: `sector_xfer`

## Requirements
- R1: After reset, `busy_n`, `data_en_n` and `end_irq_n` are 1. `data_ready`, `xfer_end`, `done` and `dma_valid` are 0. `count_q`, `addr_q`, `dma_base_q` and `dest_q` are 0.
- R2: `start` is ignored while `out_en` is 0. An accepted start does four things at the next edge: it clears `count_q[15:12]`, drives `busy_n` low, clears `xfer_end` and `data_ready`, and stores the code in `dest_q`.
- R3: Codes 2 and 3 select host mode, which drives `data_en_n` low and sets `data_ready`. Code 4 selects PCM, code 5 program memory and code 7 word memory. Codes 0, 1 and 6 launch no transfer and leave `data_en_n` high.
- R4: A `host_rd` strobe while `data_en_n` is 0 puts the buffer word at `addr_q[13:1]` on `host_data` after the next edge. Bit 0 of the address is ignored and the address wraps within 14 bits. The same strobe adds 2 to `addr_q` and subtracts 2 from `count_q`.
- R5: A `host_rd` strobe while `data_en_n` is 1 puts 16'hFFFF on `host_data` and changes neither `addr_q` nor `count_q`.
- R6: A transfer ends when a host read takes `count_q`, read as a signed 16-bit value, to zero or below, or when the last DMA word has been issued. At the end, `count_q` becomes 16'hF000; `busy_n` and `data_en_n` go to 1; `end_irq_n` goes to 0; `data_ready` goes to 0 and `xfer_end` to 1. `dest_q` is kept. `done` is high for exactly the cycle in which `end_irq_n` first reads 0.
- R7: A DMA transfer issues (`count_q[11:0]`+1)/2 words. The first destination byte address is (`dma_base_q`<<2) AND 0xFFC for PCM and `dma_base_q`<<3 for codes 5 and 7. It then advances by 2 per word. The source word follows `addr_q`, wrapping at 0x4000.
- R8: A word whose destination byte address is at or past its memory's size (0x1000, 0x80000, 0x40000) is not written, but it still consumes a source word.
- R9: After a DMA transfer of W words, `addr_q` has grown by 2W and `dma_base_q` has grown by W/2 for PCM or W/4 otherwise.
- R10: The DMA port obeys the valid/ready rule above, so back-pressure stalls the transfer with no loss or duplication.
- R11: An `ack` pulse sets `end_irq_n` to 1 and clears `count_q[15:12]`.
- R12: While `out_en` is 0, `busy_n` and `data_en_n` are held at 1 and any DMA transfer is abandoned without an end event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en | input | 1 | Data output enable level |
| start | input | 1 | Start pulse |
| start_dest | input | 3 | Destination code carried by start |
| host_rd | input | 1 | Host read strobe |
| ack | input | 1 | Transfer-end acknowledge pulse |
| ld_count | input | 1 | Load byte counter |
| count_in | input | 16 | Byte counter load value |
| ld_addr | input | 1 | Load buffer address counter |
| addr_in | input | 16 | Buffer address load value |
| ld_dma | input | 1 | Load DMA base address |
| dma_base_in | input | 16 | DMA base load value |
| buf_rd_data | input | 16 | Buffer word, big-endian |
| dma_ready | input | 1 | Destination accepts a word |
| buf_rd_addr | output | 13 | Buffer word index |
| host_data | output | 16 | Host read data |
| dma_valid | output | 1 | DMA word valid |
| dma_waddr | output | 21 | DMA destination byte address |
| dma_wdata | output | 16 | DMA word |
| dma_dest | output | 3 | Destination code of DMA word |
| count_q | output | 16 | Byte counter |
| addr_q | output | 16 | Buffer address counter |
| dma_base_q | output | 16 | DMA base address |
| dest_q | output | 3 | Stored destination code |
| busy_n | output | 1 | Transfer busy, active-low |
| data_en_n | output | 1 | Host data enable, active-low |
| end_irq_n | output | 1 | Transfer-end interrupt pending, active-low |
| data_ready | output | 1 | Host data ready flag |
| xfer_end | output | 1 | End-of-transfer flag |
| done | output | 1 | One-cycle end pulse |

## Verification
The bench builds the block with its default parameters: a 12-bit count field under 4 sticky bits, a 14-bit buffer address and the three memory limits of 4 KiB, 512 KiB and 256 KiB. These values let directed cases reach the interesting corners. A PCM base lands 8 bytes below the 4 KiB limit, a word-memory base lands just under 256 KiB, and source addresses sit next to 0x3FFF, which forces both the dropped-word rule and the source wrap within a few words. Random transfers of up to about 256 words, under random back-pressure, cover all five codes in a few thousand cycles.

// File: rtl/sxe_pkg.sv
package sxe_pkg;
  typedef enum logic [1:0] {KIND_NONE, KIND_HOST, KIND_DMA} xfer_kind_e;

  localparam logic [2:0] CODE_PCM = 3'd4;
  localparam logic [2:0] CODE_PRG = 3'd5;
  localparam logic [2:0] CODE_WRD = 3'd7;

  function automatic xfer_kind_e classify(input logic [2:0] code);
    case (code)
      3'd2, 3'd3:                   return KIND_HOST;
      CODE_PCM, CODE_PRG, CODE_WRD: return KIND_DMA;
      default:                      return KIND_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sxe_dma_seq.sv
module sxe_dma_seq #(
  parameter int LEN_W   = 12,
  parameter int BASE_W  = 16,
  parameter int DST_AW  = 21,
  parameter int PCM_LIM = 32'h1000,
  parameter int PRG_LIM = 32'h80000,
  parameter int WRD_LIM = 32'h40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [2:0]        code,
  input  logic [LEN_W-1:0]  count_lo,
  input  logic [BASE_W-1:0] base,
  input  logic              abort,
  input  logic              dma_ready,
  output logic              dma_valid,
  output logic [DST_AW-1:0] dma_waddr,
  output logic [2:0]        dma_dest,
  output logic              step,
  output logic              fin,
  output logic [LEN_W-1:0]  words_tot,
  output logic              is_pcm
);
  import sxe_pkg::*;
  localparam int WC_W = LEN_W;

  logic              active;
  logic [WC_W-1:0]   left;
  logic [DST_AW-1:0] dst, limit, dst_init, lim_init;
  logic [WC_W-1:0]   first_w;
  logic              in_range;

  assign first_w = WC_W'(({1'b0, count_lo} + (LEN_W+1)'(1)) >> 1);

  always_comb begin
    case (code)
      CODE_PCM: begin
        dst_init = DST_AW'({base, 2'b00}) & DST_AW'(PCM_LIM - 4);
        lim_init = DST_AW'(PCM_LIM);
      end
      CODE_PRG: begin
        dst_init = DST_AW'({base, 3'b000});
        lim_init = DST_AW'(PRG_LIM);
      end
      default: begin
        dst_init = DST_AW'({base, 3'b000});
        lim_init = DST_AW'(WRD_LIM);
      end
    endcase
  end

  assign in_range  = dst < limit;
  assign dma_valid = active && (left != '0) && in_range;
  assign step      = active && (left != '0) && (!in_range || dma_ready) && !abort;
  assign fin       = active && (left == '0) && !abort;
  assign dma_waddr = dst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      left      <= '0;
      words_tot <= '0;
      dst       <= '0;
      limit     <= '0;
      is_pcm    <= 1'b0;
      dma_dest  <= '0;
    end else if (abort) begin
      active <= 1'b0;
    end else if (go) begin
      active    <= 1'b1;
      left      <= first_w;
      words_tot <= first_w;
      dst       <= dst_init;
      limit     <= lim_init;
      is_pcm    <= (code == CODE_PCM);
      dma_dest  <= code;
    end else if (fin) begin
      active <= 1'b0;
    end else if (step) begin
      left <= left - WC_W'(1);
      dst  <= dst + DST_AW'(2);
    end
  end

  assert_pcm_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && is_pcm) |-> (dma_waddr < DST_AW'(PCM_LIM)));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && !dma_ready && !abort) |=> (dma_valid && $stable(dma_waddr)));
endmodule

// File: rtl/sxe_status.sv
module sxe_status (
  input  logic clk,
  input  logic rst_n,
  input  logic out_en,
  input  logic start_ok,
  input  logic host_kind,
  input  logic end_ev,
  input  logic ack,
  output logic busy_n,
  output logic data_en_n,
  output logic end_irq_n,
  output logic data_ready,
  output logic xfer_end,
  output logic done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_n     <= 1'b1;
      data_en_n  <= 1'b1;
      end_irq_n  <= 1'b1;
      data_ready <= 1'b0;
      xfer_end   <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= end_ev;
      if (end_ev) begin
        busy_n     <= 1'b1;
        data_en_n  <= 1'b1;
        end_irq_n  <= 1'b0;
        data_ready <= 1'b0;
        xfer_end   <= 1'b1;
      end else begin
        if (!out_en) begin
          busy_n    <= 1'b1;
          data_en_n <= 1'b1;
        end else if (start_ok) begin
          busy_n     <= 1'b0;
          xfer_end   <= 1'b0;
          data_ready <= host_kind;
          if (host_kind) data_en_n <= 1'b0;
        end
        if (ack) end_irq_n <= 1'b1;
      end
    end
  end

  assert_done_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !end_irq_n);
  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(end_irq_n) |-> done);
  assert_enable_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !data_en_n |-> !busy_n);
  assert_outen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en && !end_ev) |=> (busy_n && data_en_n));
endmodule

// File: rtl/sector_xfer.sv
module sector_xfer #(
  parameter int CNT_W   = 16,
  parameter int LEN_W   = 12,
  parameter int BUF_AW  = 14,
  parameter int DST_AW  = 21,
  parameter int PCM_LIM = 32'h1000,
  parameter int PRG_LIM = 32'h80000,
  parameter int WRD_LIM = 32'h40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_en,
  input  logic              start,
  input  logic [2:0]        start_dest,
  input  logic              host_rd,
  input  logic              ack,
  input  logic              ld_count,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              ld_addr,
  input  logic [CNT_W-1:0]  addr_in,
  input  logic              ld_dma,
  input  logic [CNT_W-1:0]  dma_base_in,
  input  logic [15:0]       buf_rd_data,
  input  logic              dma_ready,
  output logic [BUF_AW-2:0] buf_rd_addr,
  output logic [15:0]       host_data,
  output logic              dma_valid,
  output logic [DST_AW-1:0] dma_waddr,
  output logic [15:0]       dma_wdata,
  output logic [2:0]        dma_dest,
  output logic [CNT_W-1:0]  count_q,
  output logic [CNT_W-1:0]  addr_q,
  output logic [CNT_W-1:0]  dma_base_q,
  output logic [2:0]        dest_q,
  output logic              busy_n,
  output logic              data_en_n,
  output logic              end_irq_n,
  output logic              data_ready,
  output logic              xfer_end,
  output logic              done
);
  import sxe_pkg::*;
  localparam int STICKY = CNT_W - LEN_W;
  localparam logic [CNT_W-1:0] END_VAL = {{STICKY{1'b1}}, {LEN_W{1'b0}}};

  xfer_kind_e       kind;
  logic             start_ok, honour, host_end, end_ev, go, step, fin, is_pcm;
  logic [CNT_W-1:0] cnt_dec;
  logic [LEN_W-1:0] words_tot;

  assign kind     = classify(start_dest);
  assign start_ok = start && out_en;
  assign go       = start_ok && (kind == KIND_DMA);
  assign honour   = host_rd && !data_en_n;
  assign cnt_dec  = count_q - CNT_W'(2);
  assign host_end = honour && (cnt_dec[CNT_W-1] || (cnt_dec == '0));
  assign end_ev   = host_end || fin;

  assign buf_rd_addr = addr_q[BUF_AW-1:1];
  assign dma_wdata   = buf_rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q    <= '0;
      addr_q     <= '0;
      dma_base_q <= '0;
      dest_q     <= '0;
      host_data  <= '0;
    end else begin
      if (ld_count)                count_q <= count_in;
      else if (end_ev)             count_q <= END_VAL;
      else if (honour)             count_q <= cnt_dec;
      else if (start_ok || ack)    count_q[CNT_W-1:LEN_W] <= '0;

      if (ld_addr)                 addr_q <= addr_in;
      else if (honour || step)     addr_q <= addr_q + CNT_W'(2);

      if (ld_dma)                  dma_base_q <= dma_base_in;
      else if (fin)                dma_base_q <= dma_base_q +
                                     (is_pcm ? CNT_W'(words_tot >> 1) : CNT_W'(words_tot >> 2));

      if (start_ok)                dest_q <= start_dest;

      if (honour)                  host_data <= buf_rd_data;
      else if (host_rd)            host_data <= 16'hFFFF;
    end
  end

  sxe_dma_seq #(
    .LEN_W(LEN_W), .BASE_W(CNT_W), .DST_AW(DST_AW),
    .PCM_LIM(PCM_LIM), .PRG_LIM(PRG_LIM), .WRD_LIM(WRD_LIM)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .go(go), .code(start_dest),
    .count_lo(count_q[LEN_W-1:0]), .base(dma_base_q), .abort(!out_en),
    .dma_ready(dma_ready), .dma_valid(dma_valid), .dma_waddr(dma_waddr),
    .dma_dest(dma_dest), .step(step), .fin(fin), .words_tot(words_tot),
    .is_pcm(is_pcm)
  );

  sxe_status status_i (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .start_ok(start_ok),
    .host_kind(kind == KIND_HOST), .end_ev(end_ev), .ack(ack),
    .busy_n(busy_n), .data_en_n(data_en_n), .end_irq_n(end_irq_n),
    .data_ready(data_ready), .xfer_end(xfer_end), .done(done)
  );

  assert_end_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(ld_count)) |-> (count_q == END_VAL && busy_n && data_en_n));
  assert_blank_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && data_en_n) |=> (host_data == 16'hFFFF));
endmodule

// File: tb/sector_xfer_tb_top.sv
module sector_xfer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        out_en = 1'b1, start = 1'b0, host_rd = 1'b0, ack = 1'b0;
  logic [2:0]  start_dest = '0;
  logic        ld_count = 1'b0, ld_addr = 1'b0, ld_dma = 1'b0, dma_ready = 1'b0;
  logic [15:0] count_in = '0, addr_in = '0, dma_base_in = '0;
  logic [15:0] buf_rd_data, host_data, dma_wdata, count_q, addr_q, dma_base_q;
  logic [12:0] buf_rd_addr;
  logic        dma_valid, busy_n, data_en_n, end_irq_n, data_ready, xfer_end, done;
  logic [20:0] dma_waddr;
  logic [2:0]  dma_dest, dest_q;

  int nchk = 0, nerr = 0;

  function automatic logic [15:0] bufword(input logic [12:0] i);
    return ({3'b000, i} * 16'h0131) ^ 16'hC3A5;
  endfunction

  assign buf_rd_data = bufword(buf_rd_addr);

  sector_xfer dut_i (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .start(start), .start_dest(start_dest),
    .host_rd(host_rd), .ack(ack), .ld_count(ld_count), .count_in(count_in),
    .ld_addr(ld_addr), .addr_in(addr_in), .ld_dma(ld_dma), .dma_base_in(dma_base_in),
    .buf_rd_data(buf_rd_data), .dma_ready(dma_ready), .buf_rd_addr(buf_rd_addr),
    .host_data(host_data), .dma_valid(dma_valid), .dma_waddr(dma_waddr),
    .dma_wdata(dma_wdata), .dma_dest(dma_dest), .count_q(count_q), .addr_q(addr_q),
    .dma_base_q(dma_base_q), .dest_q(dest_q), .busy_n(busy_n), .data_en_n(data_en_n),
    .end_irq_n(end_irq_n), .data_ready(data_ready), .xfer_end(xfer_end), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [15:0] c, input logic [15:0] a, input logic [15:0] b);
    ld_count = 1; count_in = c; ld_addr = 1; addr_in = a; ld_dma = 1; dma_base_in = b;
    tick();
    ld_count = 0; ld_addr = 0; ld_dma = 0;
    ack = 1; tick(); ack = 0;
  endtask

  task automatic kick(input logic [2:0] code);
    start = 1; start_dest = code; tick(); start = 0;
  endtask

  task automatic hread();
    host_rd = 1; tick(); host_rd = 0;
  endtask

  function automatic logic [15:0] src_word(input logic [15:0] a0, input int idx);
    logic [15:0] a;
    a = ((a0 & 16'h3FFE) + 16'(2 * idx)) & 16'h3FFF;
    return bufword(a[13:1]);
  endfunction

  task automatic run_host(input logic [2:0] code, input logic [15:0] cnt, input logic [15:0] a0);
    logic [15:0] c;
    load(cnt, a0, 16'h0);
    kick(code);
    chk("R3 host enable", {busy_n, data_en_n, data_ready}, 3'b001);
    chk("R2 sticky bits cleared", count_q, cnt & 16'h0FFF);
    c = cnt & 16'h0FFF;
    for (int k = 0; k < 4096; k++) begin
      hread();
      chk("R4 host word", host_data, src_word(a0, k));
      chk("R4 address step", addr_q, a0 + 16'(2 * (k + 1)));
      c = c - 16'd2;
      if (c[15] || c == 16'd0) begin
        chk("R6 end pulse with irq", {done, end_irq_n}, 2'b10);
        chk("R6 end count", count_q, 16'hF000);
        chk("R6 end flags", {busy_n, data_en_n, data_ready, xfer_end, dest_q}, {4'b1101, code});
        tick();
        chk("R6 done one cycle", done, 1'b0);
        break;
      end
      chk("R4 count step", count_q, c);
    end
  endtask

  task automatic run_dma(input logic [2:0] code, input logic [15:0] cnt, input logic [15:0] a0,
                         input logic [15:0] base, input int rdy_pct);
    int words, dst0, lim, idx, nwr, expwr, prev_irq;
    bit fin_seen;
    words = (int'(cnt & 16'h0FFF) + 1) / 2;
    dst0 = (code == 3'd4) ? ((int'(base) << 2) & 32'hFFC) : (int'(base) << 3);
    lim = (code == 3'd4) ? 32'h1000 : (code == 3'd5) ? 32'h80000 : 32'h40000;
    expwr = 0;
    for (int k = 0; k < words; k++) if (dst0 + 2 * k < lim) expwr++;
    load(cnt, a0, base);
    kick(code);
    idx = 0; nwr = 0; fin_seen = 0; prev_irq = 1;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      dma_ready = (($urandom % 100) < rdy_pct);
      #1;
      if (done) begin
        fin_seen = 1;
        chk("R6 irq falls with done", {prev_irq[0], end_irq_n}, 2'b10);
        break;
      end
      prev_irq = end_irq_n;
      if (dma_valid && dma_ready) begin
        while (idx < words && dst0 + 2 * idx >= lim) idx++;
        chk("R7 dma address", dma_waddr, dst0 + 2 * idx);
        chk("R10 dma data", dma_wdata, src_word(a0, idx));
        chk("R7 dma dest", dma_dest, code);
        idx++; nwr++;
      end
      @(posedge clk);
      @(negedge clk);
    end
    dma_ready = 0;
    chk("R6 dma end seen", fin_seen, 1'b1);
    chk("R8 write count", nwr, expwr);
    chk("R9 addr advance", addr_q, a0 + 16'(2 * words));
    chk("R9 base advance", dma_base_q,
        base + ((code == 3'd4) ? 16'(words / 2) : 16'(words / 4)));
    chk("R6 dma end flags", {count_q, busy_n, xfer_end}, {16'hF000, 2'b11});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) tick();
    chk("R1 reset flags", {busy_n, data_en_n, end_irq_n, data_ready, xfer_end, done, dma_valid},
        7'b1110000);
    chk("R1 reset regs", {count_q, addr_q}, 32'h0);
    rst_n = 1; tick();
    chk("R1 after release", {dma_base_q, 13'h0, dest_q}, 32'h0);

    // R5: read without enable
    hread();
    chk("R5 blank data", host_data, 16'hFFFF);
    chk("R5 nothing moves", {count_q, addr_q}, 32'h0);

    // R2: start ignored with out_en low
    out_en = 0; kick(3'd2); out_en = 1; tick();
    chk("R2 start ignored", {busy_n, data_en_n, dest_q}, 5'b11000);

    // R4/R6: odd start address near top, sticky bits in count
    run_host(3'd2, 16'hA00B, 16'h3FF9);
    chk("R11 irq still pending", end_irq_n, 1'b0);
    ack = 1; tick(); ack = 0;
    chk("R11 ack clears", {end_irq_n, count_q}, {1'b1, 16'h0000});
    run_host(3'd3, 16'h0000, 16'h0040);
    run_host(3'd2, 16'h0001, 16'h1234);

    // R12: abort host mode
    load(16'd20, 16'h0200, 16'h0);
    kick(3'd2);
    hread();
    out_en = 0; tick();
    chk("R12 abort flags", {busy_n, data_en_n, end_irq_n}, 3'b111);
    hread();
    chk("R12 reads blank after abort", host_data, 16'hFFFF);
    out_en = 1; tick();

    // R3: invalid code
    load(16'd8, 16'h0, 16'h0);
    kick(3'd6);
    chk("R3 invalid code", {busy_n, data_en_n, data_ready, dest_q}, 6'b010110);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R3 no dma for invalid", dma_valid, 1'b0);
    end

    // R8: PCM window overflow, word memory near limit, zero count
    run_dma(3'd4, 16'd9, 16'h0100, 16'h03FE, 100);
    run_dma(3'd7, 16'd19, 16'h0800, 16'h7FFF, 70);
    run_dma(3'd5, 16'h5000, 16'h0300, 16'h0010, 100);
    // R7: source wrap under back-pressure
    run_dma(3'd5, 16'd40, 16'h3FF0, 16'h0123, 40);

    // R12: abandon a DMA
    load(16'd60, 16'h0, 16'h0);
    kick(3'd5);
    repeat (3) tick();
    out_en = 0; tick();
    chk("R12 dma abandoned", {dma_valid, busy_n, end_irq_n}, 3'b011);
    tick(); out_en = 1; tick();
    chk("R12 no end event", {done, xfer_end}, 2'b00);

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [2:0] code;
      logic [15:0] c, a, b;
      case ($urandom % 5)
        0: code = 3'd2; 1: code = 3'd3; 2: code = 3'd4; 3: code = 3'd5; default: code = 3'd7;
      endcase
      c = 16'($urandom) & 16'hF1FF;
      a = 16'($urandom);
      b = 16'($urandom);
      if (code == 3'd2 || code == 3'd3) run_host(code, c, a);
      else run_dma(code, c, a, b, 20 + int'($urandom % 81));
    end

    summary();
  end
endmodule